// File: doc/BRIEF.md
# Multibit Trie Longest-Prefix-Match Engine

This block resolves a 32-bit destination key to a next-hop value by longest-prefix match. The prefix table lives in an on-chip RAM as a multibit trie. Each node has eight entries, and the walk consumes three key bits per level, starting from the most significant end. An entry can carry a next-hop value, a pointer to a child node, both of them, or neither. As the engine descends, it keeps the deepest valid next hop it has passed. When the walk stops, that value is the answer.

Software prepares the table in advance. It expands each prefix to stride boundaries, and wherever two expansions land on the same entry, the longer prefix is kept. Software then loads each entry through a single-cycle write port addressed by node number and slot. A lookup begins with a one-cycle `start` pulse. The engine issues one RAM read per cycle, one read per level. It then pulses `done` and holds the result until the next lookup completes. A 32-bit key spans ten 3-bit levels followed by a final 2-bit level.

Top module: `lpm_trie_engine`

## Requirements
- R1: After reset, `busy`, `done`, `hit` and `next_hop` are all 0.
- R2: Node 0 is the root. The first entry read is root slot `key[31:29]`. At level L (L = 0..9), the slot is `key[31-3L -: 3]`.
- R3: An entry with its child-valid flag set makes the walk read the named child node at the next level. An entry without that flag ends the walk after that read.
- R4: The result is the next hop of the deepest entry read that has its next-hop-valid flag set. A shallower next hop survives when deeper entries carry none.
- R5: When no entry read carries a valid next hop, the engine reports `hit`=0 with `next_hop`=0.
- R6: The final level (level 10) uses slot `{1'b0, key[1:0]}`. Entries 4 to 7 of a node reached at that level are never read.
- R7: `done` rises exactly N clock cycles after the edge that accepts `start`, where N is the number of entries read. There is one read per level.
- R8: `done` is a single-cycle pulse. `hit` and `next_hop` change only on the edge that raises `done`, and they hold until the next completion.
- R9: A `start` that arrives while `busy` is 1 is ignored. It neither changes the lookup in flight nor queues a second one.
- R10: A write with `wr_en`=1 stores `{wr_nh_vld, wr_nh, wr_ptr_vld, wr_ptr}` at entry (`wr_node`, `wr_slot`). Any lookup started after that write sees the new entry.
- R11: A child-valid flag on a level-10 entry is not followed, so a walk reads at most 11 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a lookup of `key` (accepted when idle) |
| key | input | 32 | Destination key to resolve |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A valid next hop was found |
| next_hop | output | 8 | Resolved next hop (0 on miss) |
| wr_en | input | 1 | Write one table entry |
| wr_node | input | 6 | Node number of the entry written |
| wr_slot | input | 3 | Slot within the node |
| wr_nh_vld | input | 1 | Next-hop-valid flag for the entry |
| wr_nh | input | 8 | Next-hop value for the entry |
| wr_ptr_vld | input | 1 | Child-valid flag for the entry |
| wr_ptr | input | 6 | Child node number for the entry |

## Verification
A wrong level counter, or a wrong slot extraction, sends the walk to a different entry. The effect reaches the ports on the completing lookup, either as a wrong `next_hop` or as a `done` that arrives a cycle early or late, because the latency equals the number of entries read. A lost running-best register shows up as a shallower or missing next hop when the walk ends. A stuck state machine shows up as `busy` staying high, or as an ignored start being served. The reference model walks its own mirror of the table and predicts the exact completion cycle, so each of these faults surfaces on the first lookup whose path crosses the faulty state.

// File: rtl/lpm_trie_pkg.sv
// Package: shared types for the trie lookup engine.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lpm_trie_pkg;

    // Walk controller states.
    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WALK = 1'b1
    } walk_state_e;

endpackage

// File: rtl/trie_entry_ram.sv
// Module: trie_entry_ram
// Single-port-write, single-port-read synchronous RAM holding trie entries.
// Assumes: read data is valid the cycle after re; contents are not reset,
// so the host loads every entry a walk may reach before using it.
module trie_entry_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = 9,
    parameter int EW    = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);

    logic [EW-1:0] mem [DEPTH];

    // Store a host write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read for the walk.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/trie_step.sv
// Module: trie_step
// Combinational per-level evaluation: updates the running best next hop
// and forms the child entry address for the following level.
// Assumes: entry layout {nh_v, nh, ptr_v, ptr}; lvl is the level of ent.
module trie_step #(
    parameter int ADDR_W  = 32,
    parameter int STRIDE  = 3,
    parameter int NODE_AW = 6,
    parameter int NH_W    = 8,
    parameter int NLEVELS = 11,
    parameter int LVL_W   = 4,
    localparam int EW     = 2 + NH_W + NODE_AW,
    localparam int RAM_AW = NODE_AW + STRIDE
) (
    input  logic [ADDR_W-1:0] key_q,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [EW-1:0]     ent,
    input  logic              best_v,
    input  logic [NH_W-1:0]   best_nh,
    output logic              nb_v,
    output logic [NH_W-1:0]   nb_nh,
    output logic              descend,
    output logic [RAM_AW-1:0] child_addr
);

    localparam int LAST_W = ADDR_W - STRIDE * (NLEVELS - 1);
    localparam logic [ADDR_W-1:0] LAST_MASK = ADDR_W'((64'd1 << LAST_W) - 64'd1);

    logic              e_nh_v;
    logic [NH_W-1:0]   e_nh;
    logic              e_ptr_v;
    logic [NODE_AW-1:0] e_ptr;
    int                sh;
    logic [ADDR_W-1:0] kshift;
    logic [STRIDE-1:0] child_slot;

    assign e_nh_v  = ent[EW-1];
    assign e_nh    = ent[EW-2 -: NH_W];
    assign e_ptr_v = ent[NODE_AW];
    assign e_ptr   = ent[NODE_AW-1:0];

    // Keep the deepest valid next hop seen so far.
    always_comb begin
        nb_v  = best_v | e_nh_v;
        nb_nh = e_nh_v ? e_nh : best_nh;
    end

    // Follow the child only when one exists and a deeper level remains.
    assign descend = e_ptr_v && (lvl < LVL_W'(NLEVELS - 1));

    // Extract the key bits that index the next level (short final stride).
    always_comb begin
        sh = ADDR_W - STRIDE * (int'(lvl) + 2);
        if (sh >= 0) begin
            kshift = key_q >> sh;
        end else begin
            kshift = key_q & LAST_MASK;
        end
        child_slot = kshift[STRIDE-1:0];
    end

    assign child_addr = {e_ptr, child_slot};

endmodule

// File: rtl/trie_walk_ctrl.sv
// Module: trie_walk_ctrl
// Sequences one lookup: accepts start when idle, issues one RAM read per
// level, tracks the running best, and latches the result with a done pulse.
// Assumes: RAM read latency of one cycle; starts while busy are dropped.
module trie_walk_ctrl
    import lpm_trie_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int STRIDE  = 3,
    parameter int NODE_AW = 6,
    parameter int NH_W    = 8,
    parameter int NLEVELS = 11,
    parameter int LVL_W   = 4,
    localparam int RAM_AW = NODE_AW + STRIDE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] key,
    output logic              busy,
    output logic              done,
    output logic              hit,
    output logic [NH_W-1:0]   next_hop,
    output logic [ADDR_W-1:0] key_q,
    output logic [LVL_W-1:0]  lvl,
    output logic              best_v,
    output logic [NH_W-1:0]   best_nh,
    input  logic              nb_v,
    input  logic [NH_W-1:0]   nb_nh,
    input  logic              descend,
    input  logic [RAM_AW-1:0] child_addr,
    output logic              ram_re,
    output logic [RAM_AW-1:0] ram_raddr
);

    walk_state_e state;
    logic        launch;

    assign busy   = (state == WS_WALK);
    assign launch = (state == WS_IDLE) && start;

    // Root read on launch, child read while descending.
    assign ram_re    = launch | (busy & descend);
    assign ram_raddr = launch ? {NODE_AW'(0), key[ADDR_W-1 -: STRIDE]} : child_addr;

    // Walk state, level counter, running best and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WS_IDLE;
            lvl      <= '0;
            key_q    <= '0;
            best_v   <= 1'b0;
            best_nh  <= '0;
            done     <= 1'b0;
            hit      <= 1'b0;
            next_hop <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                WS_IDLE: begin
                    if (start) begin
                        key_q   <= key;
                        lvl     <= '0;
                        best_v  <= 1'b0;
                        best_nh <= '0;
                        state   <= WS_WALK;
                    end
                end
                WS_WALK: begin
                    best_v  <= nb_v;
                    best_nh <= nb_nh;
                    if (descend) begin
                        lvl <= lvl + 1'b1;
                    end else begin
                        state    <= WS_IDLE;
                        done     <= 1'b1;
                        hit      <= nb_v;
                        next_hop <= nb_v ? nb_nh : '0;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    // R8: completion is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: result registers move only together with done.
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hit) && $stable(next_hop)));

    // R5: a miss reports a zero next hop.
    p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (next_hop == '0));

    // R11: the level counter never passes the last level.
    p_depth_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lvl < LVL_W'(NLEVELS)));

    // R9: an idle engine without start stays idle.
    p_idle_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R7: an accepted start always begins a walk.
    p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

endmodule

// File: rtl/lpm_trie_engine.sv
// Module: lpm_trie_engine (top)
// Longest-prefix-match engine over a fixed-stride multibit trie in on-chip
// RAM, with a host write port for pre-expanded entries.
// Assumes: node 0 is the root; software performs prefix expansion.
module lpm_trie_engine #(
    parameter int ADDR_W  = 32,
    parameter int STRIDE  = 3,
    parameter int NODE_AW = 6,
    parameter int NH_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  key,
    output logic               busy,
    output logic               done,
    output logic               hit,
    output logic [NH_W-1:0]    next_hop,
    input  logic               wr_en,
    input  logic [NODE_AW-1:0] wr_node,
    input  logic [STRIDE-1:0]  wr_slot,
    input  logic               wr_nh_vld,
    input  logic [NH_W-1:0]    wr_nh,
    input  logic               wr_ptr_vld,
    input  logic [NODE_AW-1:0] wr_ptr
);

    localparam int SLOTS   = 1 << STRIDE;
    localparam int NODES   = 1 << NODE_AW;
    localparam int DEPTH   = NODES * SLOTS;
    localparam int RAM_AW  = NODE_AW + STRIDE;
    localparam int EW      = 2 + NH_W + NODE_AW;
    localparam int NLEVELS = (ADDR_W + STRIDE - 1) / STRIDE;
    localparam int LVL_W   = $clog2(NLEVELS + 1);

    logic [ADDR_W-1:0] key_q;
    logic [LVL_W-1:0]  lvl;
    logic              best_v;
    logic [NH_W-1:0]   best_nh;
    logic              nb_v;
    logic [NH_W-1:0]   nb_nh;
    logic              descend;
    logic [RAM_AW-1:0] child_addr;
    logic              ram_re;
    logic [RAM_AW-1:0] ram_raddr;
    logic [EW-1:0]     ram_rdata;

    trie_entry_ram #(
        .DEPTH (DEPTH),
        .AW    (RAM_AW),
        .EW    (EW)
    ) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr ({wr_node, wr_slot}),
        .wdata ({wr_nh_vld, wr_nh, wr_ptr_vld, wr_ptr}),
        .re    (ram_re),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    trie_step #(
        .ADDR_W  (ADDR_W),
        .STRIDE  (STRIDE),
        .NODE_AW (NODE_AW),
        .NH_W    (NH_W),
        .NLEVELS (NLEVELS),
        .LVL_W   (LVL_W)
    ) u_step (
        .key_q      (key_q),
        .lvl        (lvl),
        .ent        (ram_rdata),
        .best_v     (best_v),
        .best_nh    (best_nh),
        .nb_v       (nb_v),
        .nb_nh      (nb_nh),
        .descend    (descend),
        .child_addr (child_addr)
    );

    trie_walk_ctrl #(
        .ADDR_W  (ADDR_W),
        .STRIDE  (STRIDE),
        .NODE_AW (NODE_AW),
        .NH_W    (NH_W),
        .NLEVELS (NLEVELS),
        .LVL_W   (LVL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .key        (key),
        .busy       (busy),
        .done       (done),
        .hit        (hit),
        .next_hop   (next_hop),
        .key_q      (key_q),
        .lvl        (lvl),
        .best_v     (best_v),
        .best_nh    (best_nh),
        .nb_v       (nb_v),
        .nb_nh      (nb_nh),
        .descend    (descend),
        .child_addr (child_addr),
        .ram_re     (ram_re),
        .ram_raddr  (ram_raddr)
    );

endmodule

// File: tb/tb_lpm_trie_engine.sv
`timescale 1ns/1ps
module tb_lpm_trie_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] key = '0;
    logic        busy, done, hit;
    logic [7:0]  next_hop;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_node = '0;
    logic [2:0]  wr_slot = '0;
    logic        wr_nh_vld = 1'b0;
    logic [7:0]  wr_nh = '0;
    logic        wr_ptr_vld = 1'b0;
    logic [5:0]  wr_ptr = '0;

    int total = 0;
    int bad = 0;

    // Behavioural mirror of the table.
    bit m_nhv [512];
    int m_nh  [512];
    bit m_pv  [512];
    int m_ptr [512];

    always #2.5 clk = ~clk;

    lpm_trie_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key),
        .busy(busy), .done(done), .hit(hit), .next_hop(next_hop),
        .wr_en(wr_en), .wr_node(wr_node), .wr_slot(wr_slot),
        .wr_nh_vld(wr_nh_vld), .wr_nh(wr_nh),
        .wr_ptr_vld(wr_ptr_vld), .wr_ptr(wr_ptr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int node, input int slot, input bit nhv, input int nh,
                      input bit pv, input int ptr);
        @(negedge clk);
        wr_en = 1'b1; wr_node = 6'(node); wr_slot = 3'(slot);
        wr_nh_vld = nhv; wr_nh = 8'(nh); wr_ptr_vld = pv; wr_ptr = 6'(ptr);
        m_nhv[node*8+slot] = nhv; m_nh[node*8+slot] = nh;
        m_pv[node*8+slot] = pv; m_ptr[node*8+slot] = ptr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Reference walk: expected hit, next hop and number of reads.
    task automatic model(input logic [31:0] k, output bit h, output int nh, output int n);
        int node = 0;
        h = 0; nh = 0; n = 0;
        for (int l = 0; l < 11; l++) begin
            int slot = (l < 10) ? int'((k >> (29 - 3*l)) & 32'd7) : int'(k & 32'd3);
            int e = node*8 + slot;
            n++;
            if (m_nhv[e]) begin h = 1; nh = m_nh[e]; end
            if (m_pv[e] && l < 10) node = m_ptr[e];
            else break;
        end
    endtask

    // One lookup, compared cycle by cycle; inject>0 pulses a second start mid-walk.
    task automatic lookup(input logic [31:0] k, input string req, input int inject);
        bit eh; int enh; int en; int c;
        logic ph; logic [7:0] pnh;
        model(k, eh, enh, en);
        @(negedge clk);
        start = 1'b1; key = k;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        c = 0;
        while (!done && c < 16) begin
            if (c < en) chk(busy == 1'b1, req, "busy during walk", busy, 1);
            if (c == inject) begin start = 1'b1; key = ~k; end
            else start = 1'b0;
            @(posedge clk); @(negedge clk);
            c++;
        end
        start = 1'b0;
        chk(c == en, "R7", {req, " latency"}, c, en);
        chk(hit == eh, req, "hit", hit, eh);
        chk(next_hop == 8'(enh), req, "next_hop", next_hop, enh);
        ph = hit; pnh = next_hop;
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", done, 0);
        chk(hit == ph && next_hop == pnh, "R8", "result hold", next_hop, pnh);
        chk(busy == 1'b0, "R9", "idle after done", busy, 0);
    endtask

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] chain;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(hit == 0, "R1", "hit", hit, 0);
        chk(next_hop == 0, "R1", "next_hop", next_hop, 0);

        for (int n = 0; n < 64; n++)
            for (int s = 0; s < 8; s++) wr(n, s, 0, 0, 0, 0);

        // R5: empty table misses after one read
        lookup(32'h0000_0000, "R5", -1);

        // Short prefix 01* -> 11 expanded to root slots 2,3; 0100* -> 22 in node 1 slots 0..3
        wr(0, 2, 1, 11, 1, 1);
        wr(0, 3, 1, 11, 0, 0);
        for (int s = 0; s < 4; s++) wr(1, s, 1, 22, 0, 0);
        lookup(32'h4000_0000, "R4", -1);  // 01000.. -> 22
        lookup(32'h5000_0000, "R4", -1);  // 01010.. -> 11
        lookup(32'h6000_0000, "R2", -1);  // root slot 3 -> 11, one read
        lookup(32'h8000_0000, "R5", -1);  // root slot 4 empty

        // Deep chain: root slot 7 -> nodes 2..10 via slot 5 -> node 11
        wr(0, 7, 1, 7, 1, 2);
        for (int n = 2; n <= 10; n++) wr(n, 5, 0, 0, 1, n + 1);
        wr(11, 3, 1, 99, 1, 5);   // R11: child flag at last level ignored
        wr(11, 4, 1, 55, 0, 0);   // R6: unreachable slot
        chain = 32'hE000_0000;
        for (int l = 1; l <= 9; l++) chain = chain | (32'd5 << (29 - 3*l));
        lookup(chain | 32'd3, "R11", -1);
        lookup(chain | 32'd2, "R3", -1);
        lookup(chain | 32'd0, "R6", -1);
        lookup(chain | 32'd3, "R9", 3);

        // R10: rewrite root slot 0
        wr(0, 0, 1, 42, 0, 0);
        lookup(32'h0000_0000, "R10", -1);
        wr(0, 0, 1, 42, 1, 12);
        lookup(32'h1000_0000, "R10", -1);

        for (int i = 0; i < 40; i++) lookup($urandom, "R2", -1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule